// File: doc/BRIEF.md
# LED and IO Routing Multiplexer

This block decides what drives a small set of board pins: a green LED, a red LED, a dual-use strap pin, three I/O lines toward the processor and one clock line. A large pool of board signals can feed them. These are three PHY activity lines, a GPIO, an RTC interrupt, UART receive and transmit, the three processor I/O inputs, the PHY clock and a local oscillator clock. Two 16-bit control words choose the source for each output. Each output has its own 4-bit selector field. Some selector codes force a constant level, some pick an inverted line and some release the line to high impedance.

Both LEDs have status overrides that take priority over the selector. The green LED tracks the watchdog counter's top bit while the watchdog runs, and it lights while power-on reset is active. The red LED shows a blink pattern while the delayed user enable is low, and it lights while power-on reset is active. A free-running prescaler produces the blink pattern, and its half-period is a parameter. Every routed level source passes through a synchronizer first. The two clock inputs go straight to the clock output.

Top module: `led_io_router`

## Requirements
- R1: Green LED selector `led_ctrl[3:0]` works as follows: 0001/0010/0011 give PHY line 0/1/2, 0100 gives GPIO, 0101 gives RTC interrupt, 1000 gives processor I/O input 0, 1001 gives inverted UART receive, and 0000 (the reset default) gives GPIO.
- R2: Red LED selector `led_ctrl[7:4]` uses the same codes 0001 to 0101, except that 1000 gives processor I/O input 1, 1001 gives inverted UART transmit, and 0000 gives the blink pattern.
- R3: Strap selector `led_ctrl[11:8]` uses the same codes 0001 to 0101, except that 1000 gives processor I/O input 2 and 0000 gives PHY line 0.
- R4: On each of the three LED-type fields, code 0110 drives the output low and code 0111 drives it high.
- R5: Any other code on an LED-type field drives the output low. This covers 1010 to 1111, and also 1001 on the strap field.
- R6: For XIO line i (selector `io_ctrl[4i+3:4i]`), the output is enabled and its value is chosen as follows: 0000 gives PHY line i, 0011 gives RTC interrupt, and 0001 gives GPIO, UART receive or UART transmit for i = 0, 1, 2 respectively.
- R7: On an XIO field, code 0110 and every code not listed in R6 disable the line's output enable and drive its value low.
- R8: Clock selector `io_ctrl[15:12]` works as follows: 0001 gives the RTC interrupt, 0010 gives the oscillator clock, and every other code gives the PHY clock.
- R9: Green LED priority runs in this order. While `wdog_en` is high it equals `wdog_msb`. Otherwise, while `por_n` is low, it is high. Otherwise it follows R1.
- R10: Red LED priority runs in this order. While `user_en_dly` is low it shows the blink pattern. Otherwise, while `por_n` is low, it is high. Otherwise it follows R2.
- R11: The blink pattern resets low and then toggles every BLINK_DIV clock cycles.
- R12: A change on a routed level source reaches the outputs after SYNC_STAGES rising edges. `phy_clk` and `osc_clk` reach `clk_out` with no clock edge.
- R13: While `rst` is high, the synchronizers and the blink pattern hold zero. The outputs therefore reflect all-zero sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| led_ctrl | input | 16 | LED and strap selector word |
| io_ctrl | input | 16 | XIO and clock selector word |
| phy_led | input | 3 | PHY activity lines (async) |
| gpio_in | input | 1 | General-purpose input (async) |
| rtc_irq | input | 1 | RTC interrupt (async) |
| uart_rx | input | 1 | UART receive line (async) |
| uart_tx | input | 1 | UART transmit line (async) |
| xio_in | input | 3 | Processor I/O inputs (async) |
| phy_clk | input | 1 | PHY clock |
| osc_clk | input | 1 | Local oscillator clock |
| por_n | input | 1 | Power-on reset, active low |
| wdog_en | input | 1 | Watchdog running |
| wdog_msb | input | 1 | Top bit of watchdog counter |
| user_en_dly | input | 1 | Delayed user enable |
| led_green | output | 1 | Green LED drive |
| led_red | output | 1 | Red LED drive |
| strap_o | output | 1 | Strap pin drive value |
| xio_o | output | 3 | XIO drive values |
| xio_oe | output | 3 | XIO output enables |
| clk_out | output | 1 | Clock line toward processor |

## Verification
The bench builds the block with BLINK_DIV = 4 and keeps SYNC_STAGES = 2. With a four-cycle half-period, several full blink periods fit into a sixteen-cycle window. This allows both the red-LED override pattern and its selector default to be counted edge by edge. With the two-stage synchronizer, the exact cycle in which a PHY line change reaches the strap pin can be checked against the cycle just before it.

// File: rtl/lior_pkg.sv
package lior_pkg;

    typedef enum logic [3:0] {
        SEL_DEF  = 4'h0,
        SEL_PHY0 = 4'h1,
        SEL_PHY1 = 4'h2,
        SEL_PHY2 = 4'h3,
        SEL_GPIO = 4'h4,
        SEL_RTC  = 4'h5,
        SEL_OFF  = 4'h6,
        SEL_ON   = 4'h7,
        SEL_XIO  = 4'h8,
        SEL_UINV = 4'h9
    } led_code_e;

    typedef enum logic [3:0] {
        XC_DEF = 4'h0,
        XC_ALT = 4'h1,
        XC_RTC = 4'h3,
        XC_HIZ = 4'h6
    } xio_code_e;

    typedef enum logic [3:0] {
        CK_PHY = 4'h0,
        CK_RTC = 4'h1,
        CK_OSC = 4'h2
    } clk_code_e;

    localparam int NUM_LEDS = 3;
    localparam int NUM_XIO  = 3;
    localparam int FIELD_W  = 4;

    typedef struct packed {
        logic [2:0] xio;
        logic       utx;
        logic       urx;
        logic       rtc;
        logic       gpio;
        logic [2:0] phy;
    } src_t;

    localparam int SRC_W = $bits(src_t);

endpackage

// File: rtl/lior_sync.sv
module lior_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
        end else begin
            pipe[0] <= d;
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/lior_blink.sv
module lior_blink #(
    parameter int DIV = 12_500_000
) (
    input  logic clk,
    input  logic rst,
    output logic blink
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            blink <= 1'b0;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            blink <= ~blink;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lior_led_sel.sv
module lior_led_sel
    import lior_pkg::*;
#(
    parameter bit HAS_INV = 1'b1
) (
    input  logic [3:0] code,
    input  logic [2:0] phy,
    input  logic       gpio,
    input  logic       rtc,
    input  logic       xio_bit,
    input  logic       dflt,
    input  logic       inv,
    output logic       o
);
    always_comb begin
        case (code)
            SEL_DEF:  o = dflt;
            SEL_PHY0: o = phy[0];
            SEL_PHY1: o = phy[1];
            SEL_PHY2: o = phy[2];
            SEL_GPIO: o = gpio;
            SEL_RTC:  o = rtc;
            SEL_OFF:  o = 1'b0;
            SEL_ON:   o = 1'b1;
            SEL_XIO:  o = xio_bit;
            SEL_UINV: o = HAS_INV ? inv : 1'b0;
            default:  o = 1'b0;
        endcase
    end
endmodule

// File: rtl/lior_xio_sel.sv
module lior_xio_sel
    import lior_pkg::*;
(
    input  logic [3:0] code,
    input  logic       phy_bit,
    input  logic       alt,
    input  logic       rtc,
    output logic       o,
    output logic       oe
);
    always_comb begin
        o  = 1'b0;
        oe = 1'b1;
        case (code)
            XC_DEF:  o = phy_bit;
            XC_ALT:  o = alt;
            XC_RTC:  o = rtc;
            default: oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/led_io_router.sv
module led_io_router
    import lior_pkg::*;
#(
    parameter int BLINK_DIV   = 12_500_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] led_ctrl,
    input  logic [15:0] io_ctrl,
    input  logic [2:0]  phy_led,
    input  logic        gpio_in,
    input  logic        rtc_irq,
    input  logic        uart_rx,
    input  logic        uart_tx,
    input  logic [2:0]  xio_in,
    input  logic        phy_clk,
    input  logic        osc_clk,
    input  logic        por_n,
    input  logic        wdog_en,
    input  logic        wdog_msb,
    input  logic        user_en_dly,
    output logic        led_green,
    output logic        led_red,
    output logic        strap_o,
    output logic [2:0]  xio_o,
    output logic [2:0]  xio_oe,
    output logic        clk_out
);
    src_t raw, syn;
    logic blink;
    logic [NUM_LEDS-1:0] led_dflt, led_inv, led_raw;
    logic [NUM_XIO-1:0]  xio_alt;
    logic unused_ctrl_hi;

    assign unused_ctrl_hi = ^led_ctrl[15:12];

    assign raw = '{xio: xio_in, utx: uart_tx, urx: uart_rx, rtc: rtc_irq,
                   gpio: gpio_in, phy: phy_led};

    lior_sync #(.WIDTH(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(syn)
    );

    lior_blink #(.DIV(BLINK_DIV)) u_blink (
        .clk(clk), .rst(rst), .blink(blink)
    );

    // default and inverted-UART sources per LED-type output
    assign led_dflt = {syn.phy[0], blink, syn.gpio};
    assign led_inv  = {1'b0, ~syn.utx, ~syn.urx};
    assign xio_alt  = {syn.utx, syn.urx, syn.gpio};

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
        lior_led_sel #(.HAS_INV(i < 2)) u_sel (
            .code    (led_ctrl[FIELD_W*i +: FIELD_W]),
            .phy     (syn.phy),
            .gpio    (syn.gpio),
            .rtc     (syn.rtc),
            .xio_bit (syn.xio[i]),
            .dflt    (led_dflt[i]),
            .inv     (led_inv[i]),
            .o       (led_raw[i])
        );
    end

    for (genvar i = 0; i < NUM_XIO; i++) begin : g_xio
        lior_xio_sel u_sel (
            .code    (io_ctrl[FIELD_W*i +: FIELD_W]),
            .phy_bit (syn.phy[i]),
            .alt     (xio_alt[i]),
            .rtc     (syn.rtc),
            .o       (xio_o[i]),
            .oe      (xio_oe[i])
        );
    end

    // status overrides, highest priority first
    always_comb begin
        if (wdog_en)     led_green = wdog_msb;
        else if (!por_n) led_green = 1'b1;
        else             led_green = led_raw[0];

        if (!user_en_dly) led_red = blink;
        else if (!por_n)  led_red = 1'b1;
        else              led_red = led_raw[1];
    end

    assign strap_o = led_raw[2];

    always_comb begin
        case (io_ctrl[15:12])
            CK_RTC:  clk_out = syn.rtc;
            CK_OSC:  clk_out = osc_clk;
            default: clk_out = phy_clk;
        endcase
    end
endmodule

// File: rtl/lior_chk.sv
module lior_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] led_ctrl,
    input logic [15:0] io_ctrl,
    input logic [2:0]  phy_led,
    input logic        osc_clk,
    input logic        por_n,
    input logic        wdog_en,
    input logic        user_en_dly,
    input logic        led_green,
    input logic        led_red,
    input logic        strap_o,
    input logic [2:0]  xio_oe,
    input logic        clk_out
);
    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst) cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 1'b1;
    end

    a_r9_por_green: assert property (@(posedge clk) disable iff (rst)
        (!wdog_en && !por_n) |-> led_green);

    a_r10_por_red: assert property (@(posedge clk) disable iff (rst)
        (user_en_dly && !por_n) |-> led_red);

    a_r4_forced_on: assert property (@(posedge clk) disable iff (rst)
        (!wdog_en && por_n && led_ctrl[3:0] == 4'h7) |-> led_green);

    a_r7_hiz: assert property (@(posedge clk) disable iff (rst)
        (io_ctrl[3:0] == 4'h6) |-> !xio_oe[0]);

    a_r8_osc_route: assert property (@(posedge clk) disable iff (rst)
        (io_ctrl[15:12] == 4'h2) |-> (clk_out == osc_clk));

    a_r12_sync_delay: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd3 && led_ctrl[11:8] == 4'h1) |-> (strap_o == $past(phy_led[0], 2)));
endmodule

bind led_io_router lior_chk u_chk (.*);

// File: tb/sim_led_io_router.sv
`timescale 1ns/1ps
module sim_led_io_router;
    localparam int BLINK_DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] led_ctrl = 16'h0100;
    logic [15:0] io_ctrl = 16'h0000;
    logic [2:0]  phy_led = 3'b101;
    logic        gpio_in = 1'b1, rtc_irq = 1'b0, uart_rx = 1'b1, uart_tx = 1'b0;
    logic [2:0]  xio_in = 3'b010;
    logic        phy_clk = 1'b1, osc_clk = 1'b0;
    logic        por_n = 1'b1, wdog_en = 1'b0, wdog_msb = 1'b0, user_en_dly = 1'b1;
    logic        led_green, led_red, strap_o, clk_out;
    logic [2:0]  xio_o, xio_oe;

    always #2 clk = ~clk;

    led_io_router #(.BLINK_DIV(BLINK_DIV), .SYNC_STAGES(2)) u0 (.*);

    localparam logic [9:0] M_G = 10'h200, M_R = 10'h100, M_S = 10'h080,
                           M_XO = 10'h070, M_XOE = 10'h00E, M_CK = 10'h001;

    typedef struct {
        string      req;
        logic [9:0] exp;
        logic [9:0] care;
    } item_t;

    item_t q[$];
    event  ev;
    int    checks = 0;
    int    errors = 0;

    wire [9:0] act = {led_green, led_red, strap_o, xio_o, xio_oe, clk_out};

    function automatic logic [9:0] pk(logic g, logic r, logic s,
                                      logic [2:0] xo, logic [2:0] xoe, logic ck);
        return {g, r, s, xo, xoe, ck};
    endfunction

    task automatic check(string req, logic [9:0] a, logic [9:0] e, logic [9:0] care);
        checks++;
        if ((a & care) !== (e & care)) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b care=%b", req, a, e, care);
        end
    endtask

    task automatic step(int waits, string req, logic [9:0] e, logic [9:0] care);
        item_t it;
        repeat (waits) @(negedge clk);
        it.req = req; it.exp = e; it.care = care;
        q.push_back(it);
        -> ev;
        #1;
    endtask

    // monitor: pops expected items and compares once outputs have settled
    initial begin
        item_t it;
        forever begin
            @(ev);
            #0.5;
            while (q.size() > 0) begin
                it = q.pop_front();
                check(it.req, act, it.exp, it.care);
            end
        end
    end

    task automatic blink_count(string req);
        logic prev;
        int   c = 0;
        @(negedge clk);
        prev = led_red;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (led_red !== prev) c++;
            prev = led_red;
        end
        checks++;
        if (!(c == 3 || c == 4)) begin
            errors++;
            $display("FAIL %s blink toggles actual=%0d expected=3 or 4", req, c);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // R13: in reset, synchronizers and blink are zero
        step(3, "R13 reset state", pk(0, 0, 0, 3'b000, 3'b111, 1), 10'h3FF);
        @(negedge clk); rst = 1'b0;
        repeat (3) @(negedge clk);

        led_ctrl = 16'h0132; step(2, "R1 R2 R3 phy codes", pk(0, 1, 1, 0, 0, 0), M_G | M_R | M_S);
        led_ctrl = 16'h0454; step(2, "R1 R2 R3 gpio/rtc codes", pk(1, 0, 1, 0, 0, 0), M_G | M_R | M_S);
        led_ctrl = 16'h0888; step(2, "R1 R2 R3 xio codes", pk(0, 1, 0, 0, 0, 0), M_G | M_R | M_S);
        led_ctrl = 16'h0999; step(2, "R1 R2 R5 inverted uart", pk(0, 1, 0, 0, 0, 0), M_G | M_R | M_S);
        led_ctrl = 16'h0767; step(2, "R4 on/off", pk(1, 0, 1, 0, 0, 0), M_G | M_R | M_S);
        led_ctrl = 16'h0676; step(2, "R4 off/on", pk(0, 1, 0, 0, 0, 0), M_G | M_R | M_S);
        led_ctrl = 16'h0FAB; step(2, "R5 undefined codes", pk(0, 0, 0, 0, 0, 0), M_G | M_R | M_S);
        led_ctrl = 16'h0000; step(2, "R1 R3 defaults", pk(1, 0, 1, 0, 0, 0), M_G | M_S);

        io_ctrl = 16'h0000; step(2, "R6 R8 defaults", pk(0, 0, 0, 3'b101, 3'b111, 1), M_XO | M_XOE | M_CK);
        io_ctrl = 16'h1111; step(2, "R6 R8 alt sources", pk(0, 0, 0, 3'b011, 3'b111, 0), M_XO | M_XOE | M_CK);
        rtc_irq = 1'b1; io_ctrl = 16'h2333;
        step(2, "R6 R8 rtc and osc", pk(0, 0, 0, 3'b111, 3'b111, 0), M_XO | M_XOE | M_CK);
        osc_clk = 1'b1; step(0, "R12 osc combinational", pk(0, 0, 0, 0, 0, 1), M_CK);
        io_ctrl = 16'h0603; step(2, "R6 R7 mixed", pk(0, 0, 0, 3'b001, 3'b011, 1), M_XO | M_XOE | M_CK);
        io_ctrl = 16'h0666; step(2, "R7 high impedance", pk(0, 0, 0, 3'b000, 3'b000, 1), M_XO | M_XOE);
        io_ctrl = 16'hF9A5; step(2, "R7 R8 undefined", pk(0, 0, 0, 3'b000, 3'b000, 1), M_XO | M_XOE | M_CK);
        io_ctrl = 16'h0000; phy_clk = 1'b0;
        step(0, "R12 phy clock combinational", pk(0, 0, 0, 0, 0, 0), M_CK);

        // R12: two-edge synchronizer latency on PHY line 0 into strap
        led_ctrl = 16'h0100; repeat (2) @(negedge clk);
        phy_led = 3'b100;
        step(1, "R12 one edge old value", pk(0, 0, 1, 0, 0, 0), M_S);
        step(1, "R12 two edges new value", pk(0, 0, 0, 0, 0, 0), M_S);

        // R9 / R10 priorities
        led_ctrl = 16'h0066; por_n = 1'b0;
        step(1, "R9 R10 por forces on", pk(1, 1, 0, 0, 0, 0), M_G | M_R);
        wdog_en = 1'b1; wdog_msb = 1'b0;
        step(1, "R9 watchdog over por", pk(0, 1, 0, 0, 0, 0), M_G | M_R);
        wdog_msb = 1'b1;
        step(1, "R9 watchdog bit high", pk(1, 1, 0, 0, 0, 0), M_G);
        por_n = 1'b1; wdog_en = 1'b0;
        step(1, "R9 R10 selectors resume", pk(0, 0, 0, 0, 0, 0), M_G | M_R);

        // R11 / R10 blink
        user_en_dly = 1'b0; blink_count("R10 R11 override blink");
        user_en_dly = 1'b1; led_ctrl = 16'h0000; blink_count("R2 R11 default blink");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule